// File: doc/BRIEF.md
# Six-Control-Bit Arithmetic Logic Unit

This block is a purely combinational 16-bit arithmetic logic unit built from operand conditioning, not opcode decoding. Each of the two operands passes through its own conditioning stage that can clear it and then invert it. The conditioned operands meet in a function stage that forms either their sum or their bitwise AND. A final stage can invert that value and reports two status flags: one for an all-zero result and one for a negative result.

Useful operations such as constants, pass-through, subtraction and OR are not special cases. They appear as particular settings of the six independent control bits. A datapath controller drives the control word straight from an instruction field and reads the result and the flags in the same cycle. There is no clock, no reset and no pipeline register.

Top module: `alu6_top`

## Requirements
- R1: When ctrl_in[5] (clear-x) is 1 the x operand is forced to zero before conditioning continues; ctrl_in[4] (invert-x) then inverts every bit of the value that comes out of the clear step.
- R2: ctrl_in[3] (clear-y) and ctrl_in[2] (invert-y) act on the y operand in the same order as R1: clear first, invert second.
- R3: When ctrl_in[1] (add-select) is 1 the function stage produces the two's-complement sum of the conditioned operands modulo 2^16, and the carry out is discarded.
- R4: When ctrl_in[1] is 0 the function stage produces the bitwise AND of the conditioned operands.
- R5: When ctrl_in[0] (invert-out) is 1 the function-stage value is inverted bitwise as the last step. When it is 0 the value passes through unchanged.
- R6: flag_zero is 1 exactly when the 16-bit result is 0x0000.
- R7: flag_neg is 1 exactly when bit 15 of the result is 1.
- R8: Control words 6'b101010, 6'b111111 and 6'b111010 produce 0x0000, 0x0001 and 0xFFFF respectively, whatever the operands.
- R9: Control words 6'b001100, 6'b000010, 6'b010011, 6'b000000 and 6'b010101 produce x, x+y, x-y, x AND y and x OR y respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| ctrl_in | input | 6 | Control word: [5] clear-x, [4] invert-x, [3] clear-y, [2] invert-y, [1] add-select, [0] invert-out |
| result | output | 16 | Computed value |
| flag_zero | output | 1 | Result equals zero |
| flag_neg | output | 1 | Result bit 15 is set |

## Verification
The block holds no state, so a wrong intermediate value appears at the result port in the same evaluation as the stimulus, with no delay to wait out. A conditioning stage that swaps its clear and invert order shows up only when both bits are set, so vectors with clear and invert together are included. An adder that keeps its carry, or an inverter placed before the function stage, changes the result on operands picked to expose it, such as a sum that wraps to zero. The flags are compared against the expected result on every vector, so a flag tied to the wrong bit or to an intermediate value is caught at once.

// File: rtl/alu6_pkg.sv
package alu6_pkg;

    // Control word layout; field order matches the ctrl_in bit order, MSB first.
    typedef struct packed {
        logic clr_x;
        logic inv_x;
        logic clr_y;
        logic inv_y;
        logic add_sel;
        logic inv_out;
    } alu6_ctrl_t;

    localparam int unsigned CTRL_BITS = $bits(alu6_ctrl_t);

    // Number of operands that get a conditioning stage.
    localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/alu6_operand_prep.sv
module alu6_operand_prep #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] opnd_in,
    input  logic             clr_en,
    input  logic             inv_en,
    output logic [WIDTH-1:0] opnd_out
);

    logic [WIDTH-1:0] cleared_d;
    logic [WIDTH-1:0] cond_d;

    // Clear happens first, invert acts on whatever the clear step left.
    always_comb begin
        cleared_d = clr_en ? '0 : opnd_in;
        cond_d    = inv_en ? ~cleared_d : cleared_d;
    end

    assign opnd_out = cond_d;

    always_comb begin
        if (!$isunknown({opnd_in, clr_en, inv_en})) begin
            // R1 / R2: a cleared operand is flat, all zeros or all ones.
            if (clr_en) begin
                a_r1_r2_cleared_flat: assert ($countones(opnd_out) == 0 ||
                                              $countones(opnd_out) == WIDTH)
                    else $error("cleared operand is not flat");
            end
            // R1 / R2: with no clear, the bits are either kept or all flipped.
            if (!clr_en) begin
                a_r1_r2_kept_or_flipped: assert ((opnd_out ^ opnd_in) == '0 ||
                                                 (opnd_out ^ opnd_in) == '1)
                    else $error("operand conditioning mixed bits");
            end
        end
    end

endmodule

// File: rtl/alu6_func_unit.sv
module alu6_func_unit #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             add_sel,
    output logic [WIDTH-1:0] func_out
);

    logic [WIDTH:0]   sum_wide_d;
    logic [WIDTH-1:0] and_d;
    logic [WIDTH-1:0] func_d;

    always_comb begin
        sum_wide_d = {1'b0, a_in} + {1'b0, b_in};
        and_d      = a_in & b_in;
        // The carry in sum_wide_d[WIDTH] is dropped: arithmetic is modulo 2^WIDTH.
        func_d     = add_sel ? sum_wide_d[WIDTH-1:0] : and_d;
    end

    assign func_out = func_d;

    always_comb begin
        if (!$isunknown({a_in, b_in, add_sel})) begin
            // R3: subtracting one addend recovers the other, modulo 2^WIDTH.
            if (add_sel) begin
                a_r3_sum_inverts: assert (WIDTH'(func_out - b_in) == a_in)
                    else $error("sum does not subtract back");
            end
            // R4: an AND result has no bit outside either operand.
            if (!add_sel) begin
                a_r4_and_subset: assert (((func_out & ~a_in) | (func_out & ~b_in)) == '0)
                    else $error("AND result has a stray bit");
                a_r4_and_covers: assert ((a_in & b_in & ~func_out) == '0)
                    else $error("AND result misses a common bit");
            end
        end
    end

endmodule

// File: rtl/alu6_out_stage.sv
module alu6_out_stage #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] pre_in,
    input  logic             inv_en,
    output logic [WIDTH-1:0] res_out,
    output logic             zero_out,
    output logic             neg_out
);

    logic [WIDTH-1:0] res_d;
    logic             zero_d;
    logic             neg_d;

    always_comb begin
        res_d  = inv_en ? ~pre_in : pre_in;
        zero_d = (res_d == '0);
        neg_d  = res_d[WIDTH-1];
    end

    assign res_out  = res_d;
    assign zero_out = zero_d;
    assign neg_out  = neg_d;

    always_comb begin
        if (!$isunknown({pre_in, inv_en})) begin
            // R5: inversion flips every bit, otherwise nothing changes.
            if (inv_en) begin
                a_r5_all_flipped: assert ((res_out ^ pre_in) == '1)
                    else $error("output inversion incomplete");
            end else begin
                a_r5_untouched: assert (res_out == pre_in)
                    else $error("output changed without inversion");
            end
            // R6: zero flag agrees with the population count.
            a_r6_zero_flag: assert (zero_out == ($countones(res_out) == 0))
                else $error("zero flag disagrees with result");
            // R7: negative flag agrees with the signed reading.
            a_r7_neg_flag: assert (neg_out == ($signed(res_out) < 0))
                else $error("negative flag disagrees with result");
        end
    end

endmodule

// File: rtl/alu6_top.sv
module alu6_top
    import alu6_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0]     x_in,
    input  logic [WIDTH-1:0]     y_in,
    input  logic [CTRL_BITS-1:0] ctrl_in,
    output logic [WIDTH-1:0]     result,
    output logic                 flag_zero,
    output logic                 flag_neg
);

    alu6_ctrl_t       ctrl_d;
    logic [WIDTH-1:0] raw_d  [NUM_OPERANDS];
    logic             clr_d  [NUM_OPERANDS];
    logic             inv_d  [NUM_OPERANDS];
    logic [WIDTH-1:0] prep_q [NUM_OPERANDS];
    logic [WIDTH-1:0] func_d;

    always_comb begin
        ctrl_d   = alu6_ctrl_t'(ctrl_in);
        raw_d[0] = x_in;
        raw_d[1] = y_in;
        clr_d[0] = ctrl_d.clr_x;
        inv_d[0] = ctrl_d.inv_x;
        clr_d[1] = ctrl_d.clr_y;
        inv_d[1] = ctrl_d.inv_y;
    end

    // One identical conditioning stage per operand.
    for (genvar gi = 0; gi < NUM_OPERANDS; gi++) begin : g_prep
        alu6_operand_prep #(
            .WIDTH (WIDTH)
        ) i_prep (
            .opnd_in  (raw_d[gi]),
            .clr_en   (clr_d[gi]),
            .inv_en   (inv_d[gi]),
            .opnd_out (prep_q[gi])
        );
    end

    alu6_func_unit #(
        .WIDTH (WIDTH)
    ) i_func (
        .a_in     (prep_q[0]),
        .b_in     (prep_q[1]),
        .add_sel  (ctrl_d.add_sel),
        .func_out (func_d)
    );

    alu6_out_stage #(
        .WIDTH (WIDTH)
    ) i_out (
        .pre_in   (func_d),
        .inv_en   (ctrl_d.inv_out),
        .res_out  (result),
        .zero_out (flag_zero),
        .neg_out  (flag_neg)
    );

    // Port-level checks of the composed operations.
    always_comb begin
        if (!$isunknown({x_in, y_in, ctrl_in})) begin
            if (ctrl_in == 6'b111010) begin
                a_r8_all_ones: assert (&result)
                    else $error("minus-one control word gave a wrong value");
            end
            if (ctrl_in == 6'b101010) begin
                a_r8_const_zero: assert (flag_zero)
                    else $error("zero control word gave a nonzero result");
            end
            if (ctrl_in == 6'b010011) begin
                a_r9_difference: assert (WIDTH'(result + y_in) == x_in)
                    else $error("difference control word gave a wrong value");
            end
            if (ctrl_in == 6'b001100) begin
                a_r9_pass_x: assert (result == x_in)
                    else $error("pass control word altered x");
            end
        end
    end

endmodule

// File: tb/test_alu6_top.sv
module test_alu6_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] x_in = '0;
    logic [W-1:0] y_in = '0;
    logic [5:0]   ctrl_in = '0;
    logic [W-1:0] result;
    logic         flag_zero;
    logic         flag_neg;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    alu6_top #(.WIDTH(W)) i_alu6_top (
        .x_in      (x_in),
        .y_in      (y_in),
        .ctrl_in   (ctrl_in),
        .result    (result),
        .flag_zero (flag_zero),
        .flag_neg  (flag_neg)
    );

    typedef struct packed {
        logic [5:0]   c;
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic [W-1:0] r;
        logic [15:0]  tag;
    } vec_t;

    localparam int NVEC = 17;
    localparam vec_t VECS [NVEC] = '{
        '{6'b101010, 16'h1234, 16'h5678, 16'h0000, 16'd8},
        '{6'b111111, 16'hABCD, 16'h0F0F, 16'h0001, 16'd8},
        '{6'b111010, 16'h0000, 16'h7777, 16'hFFFF, 16'd8},
        '{6'b001100, 16'h8001, 16'h5555, 16'h8001, 16'd9},
        '{6'b000010, 16'hFFFF, 16'h0001, 16'h0000, 16'd3},
        '{6'b010011, 16'h0003, 16'h0005, 16'hFFFE, 16'd9},
        '{6'b000000, 16'hF0F0, 16'h3C3C, 16'h3030, 16'd4},
        '{6'b010101, 16'hF0F0, 16'h3C3C, 16'hFCFC, 16'd9},
        '{6'b000001, 16'hFFFF, 16'h00FF, 16'hFF00, 16'd5},
        '{6'b110000, 16'h1234, 16'h0F0F, 16'h0F0F, 16'd1},
        '{6'b000011, 16'h0001, 16'h0001, 16'hFFFD, 16'd5},
        '{6'b001010, 16'h7FFF, 16'h1234, 16'h7FFF, 16'd2},
        '{6'b001110, 16'h0000, 16'h4321, 16'hFFFF, 16'd2},
        '{6'b000110, 16'h0005, 16'h0002, 16'h0002, 16'd2},
        '{6'b100010, 16'h5A5A, 16'h8000, 16'h8000, 16'd1},
        '{6'b011010, 16'h0000, 16'h9999, 16'hFFFF, 16'd1},
        '{6'b000010, 16'h7FFF, 16'h0001, 16'h8000, 16'd7}
    };

    task automatic check_out(input string req, input logic [W-1:0] exp_r);
        logic exp_z;
        logic exp_n;
        exp_z = (exp_r == '0);
        exp_n = exp_r[W-1];
        checks++;
        if (result !== exp_r || flag_zero !== exp_z || flag_neg !== exp_n) begin
            errors++;
            $display("FAIL %s ctrl=%b x=%h y=%h: got r=%h z=%b n=%b, expected r=%h z=%b n=%b",
                     req, ctrl_in, x_in, y_in, result, flag_zero, flag_neg,
                     exp_r, exp_z, exp_n);
        end
    endtask

    task automatic apply(input logic [5:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
        @(posedge clk);
        ctrl_in = c;
        x_in    = x;
        y_in    = y;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [W-1:0] rx;
        logic [W-1:0] ry;

        // Idle state: all-zero inputs give AND of zeros, zero flag set (R4, R6).
        @(negedge clk);
        check_out("R6 idle", 16'h0000);

        // Directed vector table.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i].c, VECS[i].x, VECS[i].y);
            check_out($sformatf("R%0d vec%0d", VECS[i].tag, i), VECS[i].r);
        end

        // Every listed control word against random operands (R8, R9).
        for (int n = 0; n < 300; n++) begin
            rx = W'($urandom);
            ry = W'($urandom);
            apply(6'b101010, rx, ry); check_out("R8 zero",      16'h0000);
            apply(6'b111111, rx, ry); check_out("R8 one",       16'h0001);
            apply(6'b111010, rx, ry); check_out("R8 minus one", 16'hFFFF);
            apply(6'b001100, rx, ry); check_out("R9 pass x",    rx);
            apply(6'b000010, rx, ry); check_out("R9 add",       W'(rx + ry));
            apply(6'b010011, rx, ry); check_out("R9 sub",       W'(rx - ry));
            apply(6'b000000, rx, ry); check_out("R9 and",       rx & ry);
            apply(6'b010101, rx, ry); check_out("R9 or",        rx | ry);
        end

        // Corner cases: flag boundaries (R6, R7) and wrap (R3).
        apply(6'b000010, 16'h8000, 16'h8000); check_out("R3 wrap to zero", 16'h0000);
        apply(6'b001100, 16'h8000, 16'h0000); check_out("R7 min negative", 16'h8000);
        apply(6'b001100, 16'h7FFF, 16'h0000); check_out("R7 max positive", 16'h7FFF);
        apply(6'b001100, 16'h0000, 16'hFFFF); check_out("R6 zero pass",    16'h0000);
        // Clear-then-invert order on y: invert alone on 0xFFFF gives 0, clear+invert gives ones (R2).
        apply(6'b001100, 16'h00FF, 16'hFFFF); check_out("R2 clr+inv y",    16'h00FF);
        apply(6'b000100, 16'h00FF, 16'hFFFF); check_out("R2 inv y only",   16'h0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule